// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulate Unit

This execution unit sits in the datapath of a 32-bit processor and handles one operation: a signed 16×16 multiply whose product is added to a 32-bit signed addend. The unit decodes the instruction word it is given. It takes the upper or lower halfword of each of two source words, as the instruction selects. It then multiplies the two halfwords as two's-complement numbers, adds the addend, and returns the low 32 bits together with the destination register index. Register values, the condition-pass bit and the instruction word all come from outside the unit. The unit does not read a register file and does not evaluate condition codes.

Two encodings are accepted, and `alt_mode` chooses between them. The first is a single 32-bit word. The second is a pair of 16-bit halfwords packed into one 32-bit word. In the second encoding, an addend index of 15 turns the operation into a plain multiply. A sticky saturation flag records any accumulate overflow and stays set until `sat_clr` is pulsed. A malformed encoding or a forbidden register index is reported on `illegal`. The unit reports it and takes no other action.

Control uses two small state machines. The output machine has three states: OUT_IDLE, OUT_RESULT and OUT_FAULT. On every clock edge it moves to OUT_FAULT if an issued word is illegal. It moves to OUT_RESULT if an issued legal word has its condition passed. In all other cases it moves to OUT_IDLE. The saturation machine has two states, SAT_CLEAR and SAT_SET. It moves from SAT_CLEAR to SAT_SET on an overflow event. It moves from SAT_SET back to SAT_CLEAR only when `sat_clr` is high and no overflow event occurs in the same cycle.

Top module: `hmac_unit`

## Requirements
- R1: The select bit N chooses bits 31:16 of `src_a` when it is 1 and bits 15:0 when it is 0. The select bit M does the same for `src_b`. In the 32-bit encoding, N is instruction bit 5 and M is bit 6. In the paired encoding, N is bit 5 and M is bit 4. The halves that are not selected have no effect on the result.
- R2: `res_data` is the low 32 bits of (signed selected half of `src_a`) × (signed selected half of `src_b`) + (signed `addend`).
- R3: An accumulate whose exact sum differs from the sign extension of its low 32 bits sets `sat_flag` to 1 on the result edge. The flag then stays 1 through later operations that do not overflow.
- R4: `sat_clr` high at a clock edge clears `sat_flag` at that edge. If an overflow event occurs at the same edge, the flag is set instead. Reset clears the flag.
- R5: When a word is issued, `res_valid` is high for exactly one cycle after the next rising edge. `res_dest` holds the destination index during that cycle. In any cycle that follows an edge with no issue, both `res_valid` and `illegal` are low.
- R6: The 32-bit encoding is legal only when all of the following hold: bits 27:20 equal 8'h10, bit 7 is 1, bit 4 is 0, and the condition field in bits 31:28 is not 4'hF. The fields are: destination in bits 19:16, addend index in bits 15:12, second source in bits 11:8, first source in bits 3:0.
- R7: The paired encoding is legal only when bits 31:20 equal 12'hFB1 and bits 7:6 equal 00. The fields are: first source in bits 19:16, addend index in bits 15:12, destination in bits 11:8, second source in bits 3:0. An addend index of 15 makes the `addend` input irrelevant: the result is the product alone, and the flag is never set.
- R8: Any of the following makes the word illegal: an opcode mismatch, a destination or source index of 15, or a 32-bit-encoding addend index of 15. An illegal word raises `illegal` for one cycle, whatever the value of `cond_pass`. It raises no `res_valid` and leaves `sat_flag` unchanged.
- R9: A legal word issued with `cond_pass` = 0 produces no `res_valid` and leaves `sat_flag` unchanged, even when its operands would overflow.
- R10: After reset, `res_valid`, `illegal` and `sat_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | An instruction word is presented this cycle |
| alt_mode | input | 1 | 1 selects the paired 16-bit encoding, 0 the 32-bit encoding |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check outcome from outside the unit |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| addend | input | 32 | Addend register value |
| sat_clr | input | 1 | Synchronous clear of the saturation flag |
| res_valid | output | 1 | Result and destination are valid |
| res_data | output | 32 | Low 32 bits of the accumulate |
| res_dest | output | 4 | Destination register index |
| illegal | output | 1 | Issued word was malformed or used a forbidden index |
| sat_flag | output | 1 | Sticky accumulate-overflow flag |

## Verification
The assertions take for granted that `issue`, `cond_pass`, `alt_mode`, `sat_clr` and the operand buses are never unknown while reset is released. They also take for granted that `sat_clr` is not pulsed during the cycle in which the stability of `sat_flag` is checked after a failed condition. The stimulus meets both conditions. It drives every input to a defined value from time zero and changes inputs only on falling edges. It also keeps `sat_clr` low in every cycle except the dedicated clear pulses and the one test in which clear and overflow coincide on purpose.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int IDX_W  = 4;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_RESULT,
        OUT_FAULT
    } out_state_t;

    typedef enum logic {
        SAT_CLEAR,
        SAT_SET
    } sat_state_t;

    typedef struct packed {
        logic             legal;
        logic             hi_a;
        logic             hi_b;
        logic             acc_en;
        logic [IDX_W-1:0] dest;
    } dec_t;

endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
    import hmac_pkg::*;
#(
    parameter int  IW     = 32,
    parameter bit  ALT_EN = 1'b1
) (
    input  logic          alt_mode,
    input  logic [IW-1:0] instr,
    output dec_t          dec
);
    localparam logic [IDX_W-1:0] IDX_BAD = '1;

    dec_t d32;
    dec_t dalt;

    // Single-word form
    always_comb begin
        logic op_ok;
        logic idx_ok;
        op_ok  = (instr[27:20] == 8'h10) && instr[7] && !instr[4]
               && (instr[31:28] != 4'hF);
        idx_ok = (instr[19:16] != IDX_BAD) && (instr[15:12] != IDX_BAD)
               && (instr[11:8] != IDX_BAD) && (instr[3:0] != IDX_BAD);
        d32.legal  = op_ok && idx_ok;
        d32.hi_a   = instr[5];
        d32.hi_b   = instr[6];
        d32.acc_en = 1'b1;
        d32.dest   = instr[19:16];
    end

    // Paired-halfword form
    generate
        if (ALT_EN) begin : g_alt
            always_comb begin
                logic op_ok;
                logic idx_ok;
                op_ok  = (instr[31:20] == 12'hFB1) && (instr[7:6] == 2'b00);
                idx_ok = (instr[19:16] != IDX_BAD) && (instr[11:8] != IDX_BAD)
                       && (instr[3:0] != IDX_BAD);
                dalt.legal  = op_ok && idx_ok;
                dalt.hi_a   = instr[5];
                dalt.hi_b   = instr[4];
                dalt.acc_en = (instr[15:12] != IDX_BAD);
                dalt.dest   = instr[11:8];
            end
        end else begin : g_no_alt
            always_comb begin
                dalt        = '0;
                dalt.legal  = 1'b0;
            end
        end
    endgenerate

    assign dec = alt_mode ? dalt : d32;

endmodule

// File: rtl/hmac_halfsel.sv
module hmac_halfsel #(
    parameter int DW = 32,
    localparam int HW = DW / 2
) (
    input  logic [DW-1:0] word,
    input  logic          hi,
    output logic [DW-1:0] ext
);
    logic [HW-1:0] half;

    always_comb begin
        half = hi ? word[DW-1:HW] : word[HW-1:0];
        ext  = {{(DW - HW){half[HW-1]}}, half};
    end

endmodule

// File: rtl/hmac_datapath.sv
module hmac_datapath #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] addend,
    input  logic          hi_a,
    input  logic          hi_b,
    input  logic          acc_en,
    output logic [DW-1:0] sum_lo,
    output logic          ovf
);
    localparam int NOPS = 2;

    logic [DW-1:0] words [NOPS];
    logic          sels  [NOPS];
    logic [DW-1:0] exts  [NOPS];

    assign words[0] = src_a;
    assign words[1] = src_b;
    assign sels[0]  = hi_a;
    assign sels[1]  = hi_b;

    generate
        for (genvar i = 0; i < NOPS; i++) begin : g_sel
            hmac_halfsel #(.DW(DW)) u_sel (
                .word (words[i]),
                .hi   (sels[i]),
                .ext  (exts[i])
            );
        end
    endgenerate

    logic signed [DW-1:0] prod;
    logic        [DW-1:0] add_eff;
    logic        [DW:0]   exact;

    always_comb begin
        prod    = $signed(exts[0]) * $signed(exts[1]);
        add_eff = acc_en ? addend : '0;
        exact   = {prod[DW-1], prod} + {add_eff[DW-1], add_eff};
        sum_lo  = exact[DW-1:0];
        ovf     = exact[DW] ^ exact[DW-1];
    end

endmodule

// File: rtl/hmac_sticky.sv
module hmac_sticky
    import hmac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    sat_state_t sat_q;
    sat_state_t sat_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sat_q <= SAT_CLEAR;
        else        sat_q <= sat_nxt;
    end

    always_comb begin
        sat_nxt = sat_q;
        unique case (sat_q)
            SAT_CLEAR: if (set_evt)         sat_nxt = SAT_SET;
            SAT_SET:   if (clr && !set_evt) sat_nxt = SAT_CLEAR;
            default:                        sat_nxt = SAT_CLEAR;
        endcase
    end

    always_comb begin
        unique case (sat_q)
            SAT_SET: flag = 1'b1;
            default: flag = 1'b0;
        endcase
    end

    // R3: once set, only a clear can drop the flag
    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R4: a clear without a coinciding event empties the flag
    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_evt) |=> !flag);

    // R4: a coinciding event beats the clear
    p_set_beats_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
    import hmac_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int IW     = 32,
    parameter int XW     = IDX_W,
    parameter bit ALT_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          alt_mode,
    input  logic [IW-1:0] instr,
    input  logic          cond_pass,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [DW-1:0] addend,
    input  logic          sat_clr,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic [XW-1:0] res_dest,
    output logic          illegal,
    output logic          sat_flag
);
    dec_t          dec;
    logic [DW-1:0] sum_lo;
    logic          ovf;
    logic          ovf_evt;

    hmac_decode #(.IW(IW), .ALT_EN(ALT_EN)) u_decode (
        .alt_mode (alt_mode),
        .instr    (instr),
        .dec      (dec)
    );

    hmac_datapath #(.DW(DW)) u_dp (
        .src_a  (src_a),
        .src_b  (src_b),
        .addend (addend),
        .hi_a   (dec.hi_a),
        .hi_b   (dec.hi_b),
        .acc_en (dec.acc_en),
        .sum_lo (sum_lo),
        .ovf    (ovf)
    );

    assign ovf_evt = issue && dec.legal && cond_pass && ovf;

    hmac_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (ovf_evt),
        .clr     (sat_clr),
        .flag    (sat_flag)
    );

    // Output state machine
    out_state_t    out_q;
    out_state_t    out_nxt;
    logic [DW-1:0] data_q;
    logic [XW-1:0] dest_q;

    always_comb begin
        out_nxt = OUT_IDLE;
        if (issue) begin
            if (!dec.legal)     out_nxt = OUT_FAULT;
            else if (cond_pass) out_nxt = OUT_RESULT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= OUT_IDLE;
            data_q <= '0;
            dest_q <= '0;
        end else begin
            out_q <= out_nxt;
            if (out_nxt == OUT_RESULT) begin
                data_q <= sum_lo;
                dest_q <= dec.dest[XW-1:0];
            end
        end
    end

    always_comb begin
        res_valid = 1'b0;
        illegal   = 1'b0;
        unique case (out_q)
            OUT_IDLE:   ;
            OUT_RESULT: res_valid = 1'b1;
            OUT_FAULT:  illegal   = 1'b1;
            default:    ;
        endcase
        res_data = data_q;
        res_dest = dest_q;
    end

    // R5: a valid result always traces back to an issued, passed word
    p_valid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(issue && cond_pass));

    // R8: an illegal pulse always traces back to an issued word
    p_illegal_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(issue));

    // R3: the flag rises only after a legal, passed, overflowing accumulate
    p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> $past(issue && cond_pass && dec.legal && ovf));

    // R7: the product alone can never overflow
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec.acc_en |-> !ovf);

    // R9: a failed condition writes nothing and leaves the flag alone
    p_cond_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !cond_pass && dec.legal && !sat_clr)
            |=> (!res_valid && $stable(sat_flag)));

endmodule

// File: tb/test_hmac_unit.sv
`timescale 1ns/1ps
module test_hmac_unit;

    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic        alt_mode = 1'b0;
    logic [31:0] instr = '0;
    logic        cond_pass = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] addend = '0;
    logic        sat_clr = 1'b0;
    logic        res_valid;
    logic [31:0] res_data;
    logic [3:0]  res_dest;
    logic        illegal;
    logic        sat_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hmac_unit i_hmac_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .alt_mode  (alt_mode),
        .instr     (instr),
        .cond_pass (cond_pass),
        .src_a     (src_a),
        .src_b     (src_b),
        .addend    (addend),
        .sat_clr   (sat_clr),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_dest  (res_dest),
        .illegal   (illegal),
        .sat_flag  (sat_flag)
    );

    typedef struct packed {
        logic        alt;
        logic        hi_a;
        logic        hi_b;
        logic [3:0]  ra;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic [31:0] exp_res;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 4'd3, 32'h7FFF_0003, 32'h8000_0005, 32'h0000_000A, 32'h0000_0019, 1'b0},
        '{1'b0, 1'b1, 1'b0, 4'd3, 32'hFFFE_1234, 32'h0003_0007, 32'h0000_0000, 32'hFFFF_FFF2, 1'b0},
        '{1'b0, 1'b0, 1'b1, 4'd3, 32'h0000_FFFF, 32'h0100_0000, 32'h0000_0100, 32'h0000_0000, 1'b0},
        '{1'b0, 1'b1, 1'b1, 4'd3, 32'h8000_0000, 32'h8000_0000, 32'h3FFF_FFFF, 32'h7FFF_FFFF, 1'b0},
        '{1'b0, 1'b1, 1'b1, 4'd3, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h8000_0000, 1'b1},
        '{1'b0, 1'b0, 1'b0, 4'd3, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 32'h4000_8000, 1'b1},
        '{1'b1, 1'b1, 1'b0, 4'd3, 32'h0002_0000, 32'hABCD_0009, 32'h0000_0005, 32'h0000_0017, 1'b0},
        '{1'b1, 1'b0, 1'b1, 4'hF, 32'h1234_FFFD, 32'h0004_9999, 32'h7FFF_FFFF, 32'hFFFF_FFF4, 1'b0},
        '{1'b1, 1'b0, 1'b0, 4'hF, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 32'h4000_0000, 1'b0},
        '{1'b0, 1'b0, 1'b0, 4'd3, 32'hFFFF_FFFF, 32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1}
    };

    function automatic logic [31:0] enc_w(input logic [3:0] cond, input logic [3:0] rd,
            input logic [3:0] ra, input logic [3:0] rm, input logic m, input logic n,
            input logic [3:0] rn);
        return {cond, 8'h10, rd, ra, rm, 1'b1, m, n, 1'b0, rn};
    endfunction

    function automatic logic [31:0] enc_p(input logic [3:0] rn, input logic [3:0] ra,
            input logic [3:0] rd, input logic n, input logic m, input logic [3:0] rm);
        return {12'hFB1, rn, ra, rd, 2'b00, n, m, rm};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic drive(input logic alt, input logic [31:0] ins, input logic [31:0] a,
            input logic [31:0] b, input logic [31:0] c, input logic cp, input logic clr);
        @(negedge clk);
        issue = 1'b1; alt_mode = alt; instr = ins;
        src_a = a; src_b = b; addend = c; cond_pass = cp; sat_clr = clr;
        @(negedge clk);
        issue = 1'b0; cond_pass = 1'b0; sat_clr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
    endtask

    function automatic logic [31:0] vec_instr(input vec_t v, input logic [3:0] rd);
        if (v.alt) return enc_p(4'd1, v.ra, rd, v.hi_a, v.hi_b, 4'd4);
        return enc_w(4'hE, rd, v.ra, 4'd4, v.hi_b, v.hi_a, 4'd1);
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [32:0] bad [9];
        vec_t        ov;
        ov = VECS[4];

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 valid", {31'b0, res_valid}, 32'h0);
        chk("R10 illegal", {31'b0, illegal}, 32'h0);
        chk("R10 flag", {31'b0, sat_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 idle valid", {31'b0, res_valid}, 32'h0);

        // R1 R2 R3 R6 R7: vector table
        for (int i = 0; i < NV; i++) begin
            logic [3:0] rd;
            rd = 4'(i);
            clear_flag();
            drive(VECS[i].alt, vec_instr(VECS[i], rd), VECS[i].a, VECS[i].b,
                  VECS[i].c, 1'b1, 1'b0);
            chk("R5 valid", {31'b0, res_valid}, 32'h1);
            chk("R2 result", res_data, VECS[i].exp_res);
            chk("R5 dest", {28'b0, res_dest}, {28'b0, rd});
            chk("R6 not illegal", {31'b0, illegal}, 32'h0);
            chk("R3 flag", {31'b0, sat_flag}, {31'b0, VECS[i].exp_ovf});
            @(negedge clk);
            chk("R5 single pulse", {31'b0, res_valid}, 32'h0);
        end

        // R9: condition failed on an overflowing word
        clear_flag();
        drive(1'b0, vec_instr(ov, 4'd2), ov.a, ov.b, ov.c, 1'b0, 1'b0);
        chk("R9 no valid", {31'b0, res_valid}, 32'h0);
        chk("R9 no illegal", {31'b0, illegal}, 32'h0);
        chk("R9 flag kept", {31'b0, sat_flag}, 32'h0);

        // R8: illegal words, each with overflowing operands
        bad[0] = {1'b0, enc_w(4'hF, 4'd2, 4'd3, 4'd4, 1'b1, 1'b1, 4'd1)};
        bad[1] = {1'b0, enc_w(4'hE, 4'hF, 4'd3, 4'd4, 1'b1, 1'b1, 4'd1)};
        bad[2] = {1'b0, enc_w(4'hE, 4'd2, 4'hF, 4'd4, 1'b1, 1'b1, 4'd1)};
        bad[3] = {1'b0, enc_w(4'hE, 4'd2, 4'd3, 4'hF, 1'b1, 1'b1, 4'd1)};
        bad[4] = {1'b0, enc_w(4'hE, 4'd2, 4'd3, 4'd4, 1'b1, 1'b1, 4'hF)};
        bad[5] = {1'b0, enc_w(4'hE, 4'd2, 4'd3, 4'd4, 1'b1, 1'b1, 4'd1) & ~32'h80};
        bad[6] = {1'b0, enc_w(4'hE, 4'd2, 4'd3, 4'd4, 1'b1, 1'b1, 4'd1) ^ 32'h0020_0000};
        bad[7] = {1'b1, enc_p(4'd1, 4'd3, 4'hF, 1'b1, 1'b1, 4'd4)};
        bad[8] = {1'b1, enc_p(4'd1, 4'd3, 4'd2, 1'b1, 1'b1, 4'd4) | 32'h40};
        for (int k = 0; k < 9; k++) begin
            drive(bad[k][32], bad[k][31:0], ov.a, ov.b, ov.c, (k % 2) == 0, 1'b0);
            chk("R8 illegal", {31'b0, illegal}, 32'h1);
            chk("R8 no valid", {31'b0, res_valid}, 32'h0);
            chk("R8 flag kept", {31'b0, sat_flag}, 32'h0);
        end

        // R3: flag stays set after a clean operation
        drive(1'b0, vec_instr(ov, 4'd2), ov.a, ov.b, ov.c, 1'b1, 1'b0);
        chk("R3 set", {31'b0, sat_flag}, 32'h1);
        drive(1'b0, vec_instr(VECS[0], 4'd5), VECS[0].a, VECS[0].b, VECS[0].c, 1'b1, 1'b0);
        chk("R3 sticky", {31'b0, sat_flag}, 32'h1);
        chk("R2 after sticky", res_data, VECS[0].exp_res);

        // R4: clear, then clear coinciding with overflow
        clear_flag();
        chk("R4 cleared", {31'b0, sat_flag}, 32'h0);
        drive(1'b0, vec_instr(ov, 4'd2), ov.a, ov.b, ov.c, 1'b1, 1'b1);
        chk("R4 set beats clear", {31'b0, sat_flag}, 32'h1);

        // R4 R10: reset mid-run clears the flag
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R4 reset flag", {31'b0, sat_flag}, 32'h0);
        chk("R10 reset valid", {31'b0, res_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 idle illegal", {31'b0, illegal}, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule